// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block watches over software by counting a slow tick (about 1 kHz, given as a one-cycle enable `tickEn` on the system clock). Software must service it by writing a fixed key to a service register before the programmed timeout runs out. If it does not, the block emits a one-cycle system reset pulse. An optional window mode also punishes servicing that comes too early. An early-warning flag, which can drive an interrupt, is raised at a programmable count before the timeout.

Timeout, window and early-warning points each use a power-of-two code: code n stands for 2^(n+3) ticks. Software writes control and configuration into shadow registers. The tick side takes them up on its next tick, and a busy bit shows that an update is still pending. All registers sit on a simple single-cycle write port with a combinational read port.

Top module: `wdw_top`

## Requirements
- R1: After reset the block is disabled, `sysRst` and `irq` are 0, and every address reads 0. Address map: 0 control (bit0 enable, bit1 window enable), 1 config (bits 3:0 period code, bits 7:4 window code), 2 early-warning code (bits 3:0), 3 interrupt-enable set, 4 interrupt-enable clear (both read bit0 = enable), 5 flag, 6 service, 7 status (bit0 busy).
- R2: While enabled with period code p, a reset pulse follows the 2^(p+3)-th tick counted after the enable took effect, or after the last restart. The count then restarts from zero.
- R3: Period codes above 11 are stored as 11 (16384 ticks) and window codes above 10 are stored as 10 (8192 ticks). The stored values read back at address 1.
- R4: Writing 0xA5 to address 6 outside a closed window restarts the count from zero and causes no reset.
- R5: Writing any value other than 0xA5 to address 6 while enabled makes `sysRst` high in the next cycle.
- R6: With window mode on and window code w, a 0xA5 service made while fewer than 2^(w+3) ticks have been counted causes a reset. A service made at or after that count restarts the count.
- R7: With the window enable bit off, the window code has no effect: servicing is allowed at any count.
- R8: With early-warning code e, the flag (address 5 bit0) is set on the tick that brings the count to 2^(e+3). `irq` is the flag ANDed with the interrupt enable. Writing bit0 = 1 to address 3 sets the enable and writing it to address 4 clears it.
- R9: Writing bit0 = 1 to address 5 clears the flag. A flag set in the same cycle wins.
- R10: Writes to addresses 0 and 1 set busy (address 7 bit0) in the next cycle and take effect on the next tick. Busy drops after a tick that has no such write in the same cycle.
- R11: While disabled the counter stays at zero, no reset is produced and service writes are ignored. Re-enabling starts a full period.
- R12: `sysRst` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle pulse per slow tick |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data at regAddr |
| irq | output | 1 | Early-warning interrupt |
| sysRst | output | 1 | One-cycle system reset pulse |

## Verification
Every result registers exactly once. A timeout or window reset is high in the cycle right after the edge that sampled the deciding tick or service write. A bad-key reset is high in the cycle after the write. The flag and `irq` change one cycle after the tick or write that caused the change, and busy changes one cycle after the write or the applying tick. The bench drives each tick or write for a single cycle from a falling edge and samples at the next falling edge. That is exactly one edge later, so a one-cycle pulse cannot be missed or double counted. Reads are taken a little after the address settles on a falling edge.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  typedef enum logic [2:0] {
    ADDR_CTRL  = 3'd0,
    ADDR_CFG   = 3'd1,
    ADDR_EWOFF = 3'd2,
    ADDR_IESET = 3'd3,
    ADDR_IECLR = 3'd4,
    ADDR_FLAG  = 3'd5,
    ADDR_KICK  = 3'd6,
    ADDR_STAT  = 3'd7
  } wdwAddr_e;

  // strobes from the register control to the counting datapath
  typedef struct packed {
    logic tick;
    logic keyGood;
    logic keyBad;
  } wdwStrobe_t;
endpackage

// File: rtl/wdw_count.sv
module wdw_count
  import wdw_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int CNT_W      = 14,
  parameter int BASE_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdwStrobe_t        stb,
  input  logic              en,
  input  logic              winEn,
  input  logic [CODE_W-1:0] perCode,
  input  logic [CODE_W-1:0] winCode,
  input  logic [CODE_W-1:0] ewCode,
  output logic              sysRst,
  output logic              ewHit
);
  localparam int LEN_W = CNT_W + 1;

  function automatic logic [LEN_W-1:0] lenOf(input logic [CODE_W-1:0] code);
    lenOf = LEN_W'(1) << (int'(code) + BASE_SHIFT);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] cntExt, cntInc, perLen, winLen, ewLen;
  logic             winOpen, timeout, fire;

  always_comb begin
    perLen  = lenOf(perCode);
    winLen  = lenOf(winCode);
    ewLen   = lenOf(ewCode);
    cntExt  = {1'b0, cnt};
    cntInc  = cntExt + LEN_W'(1);
    winOpen = !winEn || (cntExt >= winLen);
    timeout = stb.tick && (cntInc >= perLen);
    fire    = en && (stb.keyBad || (stb.keyGood && !winOpen) ||
                     (timeout && !stb.keyGood));
    ewHit   = en && stb.tick && !stb.keyGood && !stb.keyBad && !timeout &&
              (cntInc == ewLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      sysRst <= 1'b0;
    end else begin
      sysRst <= fire && !sysRst;
      if (!en || fire || stb.keyGood) cnt <= '0;
      else if (stb.tick)              cnt <= cntInc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/wdw_regs.sv
module wdw_regs
  import wdw_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter int                CODE_W       = 4,
  parameter int                MAX_PER_CODE = 11,
  parameter int                MAX_WIN_CODE = 10,
  parameter logic [DATA_W-1:0] KEY          = 'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              ewHit,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq,
  output wdwStrobe_t        stb,
  output logic              actEn,
  output logic              actWinEn,
  output logic [CODE_W-1:0] actPer,
  output logic [CODE_W-1:0] actWin,
  output logic [CODE_W-1:0] ewCode,
  output logic              busy
);
  localparam logic [CODE_W-1:0] PER_LIM = CODE_W'(MAX_PER_CODE);
  localparam logic [CODE_W-1:0] WIN_LIM = CODE_W'(MAX_WIN_CODE);

  function automatic logic [CODE_W-1:0] clampCode(input logic [CODE_W-1:0] v,
                                                  input logic [CODE_W-1:0] lim);
    clampCode = (v > lim) ? lim : v;
  endfunction

  logic              shEn, shWinEn, ieQ, flagQ;
  logic [CODE_W-1:0] shPer, shWin;
  logic              wrCtrl, wrCfg, wrKick;

  assign wrCtrl      = regWe && (regAddr == ADDR_CTRL);
  assign wrCfg       = regWe && (regAddr == ADDR_CFG);
  assign wrKick      = regWe && (regAddr == ADDR_KICK);
  assign stb.tick    = tickEn;
  assign stb.keyGood = wrKick && (regWrData == KEY);
  assign stb.keyBad  = wrKick && (regWrData != KEY);
  assign irq         = flagQ && ieQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shEn <= 1'b0; shWinEn <= 1'b0; shPer <= '0; shWin <= '0;
      actEn <= 1'b0; actWinEn <= 1'b0; actPer <= '0; actWin <= '0;
      ewCode <= '0; busy <= 1'b0; ieQ <= 1'b0; flagQ <= 1'b0;
    end else begin
      if (tickEn && busy) begin
        actEn <= shEn; actWinEn <= shWinEn; actPer <= shPer; actWin <= shWin;
      end
      if (wrCtrl) begin
        shEn    <= regWrData[0];
        shWinEn <= regWrData[1];
      end
      if (wrCfg) begin
        shPer <= clampCode(regWrData[CODE_W-1:0], PER_LIM);
        shWin <= clampCode(regWrData[2*CODE_W-1:CODE_W], WIN_LIM);
      end
      if (wrCtrl || wrCfg) busy <= 1'b1;
      else if (tickEn)     busy <= 1'b0;
      if (regWe && (regAddr == ADDR_EWOFF))
        ewCode <= clampCode(regWrData[CODE_W-1:0], PER_LIM);
      if (regWe && (regAddr == ADDR_IESET) && regWrData[0]) ieQ <= 1'b1;
      else if (regWe && (regAddr == ADDR_IECLR) && regWrData[0]) ieQ <= 1'b0;
      if (ewHit) flagQ <= 1'b1;
      else if (regWe && (regAddr == ADDR_FLAG) && regWrData[0]) flagQ <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL:  regRdData[1:0] = {shWinEn, shEn};
      ADDR_CFG:   begin
        regRdData[CODE_W-1:0]        = shPer;
        regRdData[2*CODE_W-1:CODE_W] = shWin;
      end
      ADDR_EWOFF: regRdData[CODE_W-1:0] = ewCode;
      ADDR_IESET, ADDR_IECLR: regRdData[0] = ieQ;
      ADDR_FLAG:  regRdData[0] = flagQ;
      ADDR_STAT:  regRdData[0] = busy;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/wdw_top.sv
module wdw_top
  import wdw_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter int                CODE_W       = 4,
  parameter int                MAX_PER_CODE = 11,
  parameter int                MAX_WIN_CODE = 10,
  parameter int                BASE_SHIFT   = 3,
  parameter logic [DATA_W-1:0] KEY          = 'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq,
  output logic              sysRst
);
  localparam int CNT_W = MAX_PER_CODE + BASE_SHIFT;

  wdwStrobe_t        stb;
  logic              actEn, actWinEn, busy, ewHit;
  logic [CODE_W-1:0] actPer, actWin, ewCode;

  wdw_regs #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .MAX_PER_CODE(MAX_PER_CODE),
    .MAX_WIN_CODE(MAX_WIN_CODE), .KEY(KEY)
  ) regs_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .ewHit(ewHit), .regRdData(regRdData), .irq(irq),
    .stb(stb), .actEn(actEn), .actWinEn(actWinEn), .actPer(actPer),
    .actWin(actWin), .ewCode(ewCode), .busy(busy)
  );

  wdw_count #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT)
  ) count_i (
    .clk(clk), .rstN(rstN), .stb(stb), .en(actEn), .winEn(actWinEn),
    .perCode(actPer), .winCode(actWin), .ewCode(ewCode),
    .sysRst(sysRst), .ewHit(ewHit)
  );
endmodule

// File: rtl/wdw_chk.sv
module wdw_chk
  import wdw_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY    = 'hA5
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              regWe,
  input logic [2:0]        regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              sysRst,
  input logic              irq,
  input logic              actEn,
  input logic              busy,
  input logic              ewHit
);
  logic cfgWrite;
  assign cfgWrite = regWe && ((regAddr == ADDR_CTRL) || (regAddr == ADDR_CFG));

  assert_rst_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    sysRst |=> !sysRst);

  assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (regAddr == ADDR_KICK) && (regWrData != KEY) && actEn && !sysRst)
    |=> sysRst);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !actEn |=> !sysRst);

  assert_busy_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> busy);

  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !cfgWrite) |=> !busy);

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (regAddr == ADDR_IECLR) && regWrData[0]) |=> !irq);

  assert_flag_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (regAddr == ADDR_FLAG) && regWrData[0] && !ewHit) |=> !irq);
endmodule

bind wdw_top wdw_chk #(.DATA_W(DATA_W), .KEY(KEY)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe), .regAddr(regAddr),
  .regWrData(regWrData), .sysRst(sysRst), .irq(irq), .actEn(actEn),
  .busy(busy), .ewHit(ewHit)
);

// File: tb/wdw_top_tb_top.sv
module wdw_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_EW = 3'd2, A_IESET = 3'd3,
                         A_IECLR = 3'd4, A_FLAG = 3'd5, A_KICK = 3'd6, A_STAT = 3'd7;

  logic       clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'd0, regRdData;
  logic       irq, sysRst;
  int         nChecks = 0, nFail = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdw_top dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq), .sysRst(sysRst)
  );

  task automatic check(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doTick();
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output int d);
    @(negedge clk); regAddr = a; #1; d = int'(regRdData);
  endtask

  task automatic quietTicks(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      doTick();
      if (sysRst) hits++;
    end
    check(hits, 0, tag);
  endtask

  task automatic setup(input int per, input int win, input bit winEn,
                       input int ew, input bit en);
    regWrite(A_CTRL, 8'h00); doTick(); doTick();
    regWrite(A_EW, 8'(ew));
    regWrite(A_CFG, 8'((win << 4) | per));
    regWrite(A_CTRL, {6'd0, winEn, en});
    doTick();
    regWrite(A_FLAG, 8'h01);
  endtask

  task automatic testReset();
    int d;
    check(int'(sysRst), 0, "R1 sysRst after reset");
    check(int'(irq), 0, "R1 irq after reset");
    for (int a = 0; a < 8; a++) begin
      regRead(3'(a), d);
      check(d, 0, $sformatf("R1 address %0d reads zero", a));
    end
  endtask

  task automatic testSync();
    int d;
    setup(0, 0, 0, 15, 0);
    regWrite(A_CFG, 8'h01);
    regRead(A_STAT, d); check(d, 1, "R10 busy after config write");
    regRead(A_CFG, d);  check(d, 1, "R10 config shadow readback");
    regWrite(A_CTRL, 8'h01);
    regRead(A_STAT, d); check(d, 1, "R10 busy held until tick");
    doTick();
    regRead(A_STAT, d); check(d, 0, "R10 busy clear after tick");
    quietTicks(15, "R10 new period in effect, no early reset");
    doTick(); check(int'(sysRst), 1, "R10 reset after 16 ticks");
  endtask

  task automatic testTimeout();
    setup(0, 0, 0, 15, 1);
    quietTicks(7, "R2 no reset before 8 ticks");
    doTick(); check(int'(sysRst), 1, "R2 reset on 8th tick");
    @(negedge clk); check(int'(sysRst), 0, "R12 pulse lasts one cycle");
    quietTicks(7, "R2 count restarted after timeout");
    doTick(); check(int'(sysRst), 1, "R2 second timeout");
    setup(2, 0, 0, 15, 1);
    quietTicks(31, "R2 code 2 quiet for 31 ticks");
    doTick(); check(int'(sysRst), 1, "R2 code 2 reset on 32nd tick");
  endtask

  task automatic testKick();
    setup(0, 0, 0, 15, 1);
    quietTicks(6, "R4 before service");
    regWrite(A_KICK, 8'hA5); check(int'(sysRst), 0, "R4 valid key no reset");
    quietTicks(7, "R4 count restarted by key");
    doTick(); check(int'(sysRst), 1, "R4 timeout after restart");
  endtask

  task automatic testBadKey();
    setup(0, 0, 0, 15, 1);
    quietTicks(2, "R5 before bad key");
    regWrite(A_KICK, 8'h5A); check(int'(sysRst), 1, "R5 wrong key resets");
    quietTicks(7, "R5 count restarted after bad key");
    doTick(); check(int'(sysRst), 1, "R5 timeout after bad key");
    setup(0, 0, 0, 15, 0);
    regWrite(A_KICK, 8'h00); check(int'(sysRst), 0, "R11 wrong key ignored when disabled");
    quietTicks(40, "R11 disabled never times out");
  endtask

  task automatic testWindow();
    setup(2, 1, 1, 15, 1);
    quietTicks(15, "R6 closed window quiet");
    regWrite(A_KICK, 8'hA5); check(int'(sysRst), 1, "R6 key at count 15 in closed window");
    quietTicks(16, "R6 reach open window");
    regWrite(A_KICK, 8'hA5); check(int'(sysRst), 0, "R6 key at count 16 accepted");
    quietTicks(31, "R6 restarted by open-window key");
    doTick(); check(int'(sysRst), 1, "R6 timeout after open-window key");
  endtask

  task automatic testWindowOff();
    setup(2, 1, 0, 15, 1);
    quietTicks(3, "R7 early count");
    regWrite(A_KICK, 8'hA5); check(int'(sysRst), 0, "R7 early key accepted without window mode");
    quietTicks(31, "R7 restarted");
    doTick(); check(int'(sysRst), 1, "R7 timeout");
  endtask

  task automatic testEarlyWarn();
    int d;
    setup(2, 0, 0, 1, 1);
    regWrite(A_IESET, 8'h01);
    for (int i = 0; i < 15; i++) doTick();
    check(int'(irq), 0, "R8 no warning before 16 ticks");
    doTick();
    check(int'(irq), 1, "R8 irq on 16th tick");
    regRead(A_FLAG, d); check(d, 1, "R8 flag set");
    regWrite(A_FLAG, 8'h01);
    check(int'(irq), 0, "R9 irq drops after flag clear");
    regRead(A_FLAG, d); check(d, 0, "R9 flag cleared");
    quietTicks(15, "R8 ticks up to timeout");
    doTick(); check(int'(sysRst), 1, "R2 timeout after warning");
    for (int i = 0; i < 16; i++) doTick();
    check(int'(irq), 1, "R8 warning again after restart");
    regWrite(A_IECLR, 8'h01);
    check(int'(irq), 0, "R8 irq masked by enable clear");
    regRead(A_FLAG, d);  check(d, 1, "R8 flag kept while masked");
    regRead(A_IESET, d); check(d, 0, "R8 enable reads cleared");
  endtask

  task automatic testDisable();
    setup(0, 0, 0, 15, 1);
    quietTicks(5, "R11 partial count");
    regWrite(A_CTRL, 8'h00); doTick();
    quietTicks(20, "R11 no reset while disabled");
    regWrite(A_CTRL, 8'h01); doTick();
    quietTicks(7, "R11 full period after re-enable");
    doTick(); check(int'(sysRst), 1, "R11 timeout after re-enable");
  endtask

  task automatic testClamp();
    int d;
    setup(15, 15, 0, 15, 1);
    regRead(A_CFG, d); check(d, 8'hAB, "R3 codes clamped to 11 and 10");
    quietTicks(16383, "R3 quiet below 16384 ticks");
    doTick(); check(int'(sysRst), 1, "R3 reset at 16384 ticks");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSync();
    testTimeout();
    testKick();
    testBadKey();
    testWindow();
    testWindowOff();
    testEarlyWarn();
    testDisable();
    testClamp();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule